// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits of a short, fixed-length memory burst. When a new access starts, the caller pulses a load strobe together with the starting low address. From then on, each clock edge at which the active-low advance input is sampled low moves the output to the next address of the burst. The address stays inside an aligned block of `2**ADDR_W` addresses and wraps back to its start once every position has been visited. Read and write bursts use the same sequence.

A mode input selects one of two orders. The linear order counts upward modulo the block size from the start address. The interleaved order XORs the start address with a running beat index. Inside the block there are three state and logic pieces: a register that holds the start address, a beat counter that tracks how far the burst has advanced, and a mapping stage that combines the two according to the mode. The mode feeds only that final mapping stage. Upper address bits, array access and chip-select decoding belong to the surrounding logic.

Top module: `bst_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears itself, and `addr_o` reads 0 after that edge.
- R2: The cycle after an edge at which `load_i` is 1, `addr_o` equals the `start_i` value sampled at that edge, in either mode.
- R3: At an edge where `load_i` is 1, `adv_n_i` has no effect. The output shows the loaded start address, not the next address in the sequence.
- R4: With `mode_i` = 0 (linear), every edge with `load_i` = 0 and `adv_n_i` = 0 makes `addr_o` equal to (previous `addr_o` + 1) modulo `2**ADDR_W`. For a start of 01 with ADDR_W = 2, this gives 01, 10, 11, 00.
- R5: With `mode_i` = 1 (interleaved), after k advances since the last load `addr_o` equals start XOR (k modulo `2**ADDR_W`). For a start of 01 with ADDR_W = 2, this gives 01, 00, 11, 10.
- R6: At an edge with `load_i` = 0 and `adv_n_i` = 1, the burst position does not change. If `mode_i` stays the same, `addr_o` holds its value.
- R7: After exactly `2**ADDR_W` advances since a load, `addr_o` is back at the start address in both modes.
- R8: `mode_i` acts on `addr_o` in the same cycle, without a clock edge. Changing it mid-burst re-maps the current beat index, and the burst position is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Starts a new burst from `start_i` |
| start_i | input | ADDR_W | Starting low address of the burst |
| adv_n_i | input | 1 | Active-low advance to next burst address |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds two copies of the block. The first uses the default ADDR_W = 2, the four-beat case, where both complete orders are listed exactly and every start address is walked in both modes. The second uses ADDR_W = 3. This exposes carry propagation across more than one bit in the linear adder, and an eight-step wrap, which the two-bit build cannot show. Both copies get the same random mix of loads, advances, stalls and mid-burst mode flips.

// File: rtl/bst_pkg.sv
// Package bst_pkg
// Shared types for the burst address sequencer.
// Assumes: the order select is a single bit, with 1 meaning interleaved.
package bst_pkg;

    // Burst ordering encodings as seen on the mode input
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage : bst_pkg

// File: rtl/bst_start_reg.sv
// Module bst_start_reg
// Captures the burst start address when a load is requested and otherwise
// keeps it.
// Assumes: synchronous active-low reset, and load takes effect on the same edge.
module bst_start_reg #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_i,
    output logic [ADDR_W-1:0] start_o
);

    logic [ADDR_W-1:0] start_q;

    // Capture the start address on load; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load_i) begin
            start_q <= start_i;
        end
    end

    assign start_o = start_q;

endmodule : bst_start_reg

// File: rtl/bst_beat_ctr.sv
// Module bst_beat_ctr
// Counts the beats advanced since the last load, modulo 2**ADDR_W.
// Load has priority over advance, and the count restarts at zero.
// Assumes: adv_n_i is active low and sampled at the rising edge.
module bst_beat_ctr #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    output logic [ADDR_W-1:0] beat_o
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] beat_q;
    logic [ADDR_W-1:0] beat_d;

    // Next-count selection: load restarts, advance increments, else hold
    always_comb begin
        if (load_i) begin
            beat_d = '0;
        end else if (!adv_n_i) begin
            beat_d = beat_q + ONE;
        end else begin
            beat_d = beat_q;
        end
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign beat_o = beat_q;

endmodule : bst_beat_ctr

// File: rtl/bst_order_map.sv
// Module bst_order_map
// Combines the start address and the beat index into the burst address.
// Interleaved: bitwise XOR. Linear: ripple-carry sum modulo 2**ADDR_W.
// Assumes: purely combinational, and the mode may change in any cycle.
module bst_order_map
    import bst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] beat_i,
    input  order_e            order_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] xor_addr;
    logic [ADDR_W-1:0] lin_addr;
    logic [ADDR_W:0]   carry;

    assign carry[0] = 1'b0;

    // One bit slice per address bit: XOR term and full-adder sum
    for (genvar b = 0; b < ADDR_W; b++) begin : g_slice
        assign xor_addr[b]  = start_i[b] ^ beat_i[b];
        assign lin_addr[b]  = start_i[b] ^ beat_i[b] ^ carry[b];
        assign carry[b+1]   = (start_i[b] & beat_i[b])
                            | (carry[b] & (start_i[b] ^ beat_i[b]));
    end

    // Order selection from the live mode input
    always_comb begin
        if (order_i == ORD_INTERLEAVE) begin
            addr_o = xor_addr;
        end else begin
            addr_o = lin_addr;
        end
    end

endmodule : bst_order_map

// File: rtl/bst_addr_gen.sv
// Module bst_addr_gen
// Burst address sequencer top. Holds the start address and a beat count.
// It presents the burst address in linear or interleaved order.
// Assumes: synchronous active-low reset, and the mode acts combinationally.
module bst_addr_gen
    import bst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] start_w;
    logic [ADDR_W-1:0] beat_w;
    order_e            order_w;

    // Map the raw mode bit onto the ordering type
    assign order_w = order_e'(mode_i);

    bst_start_reg #(.ADDR_W(ADDR_W)) start_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .start_o (start_w)
    );

    bst_beat_ctr #(.ADDR_W(ADDR_W)) beat_ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat_w)
    );

    bst_order_map #(.ADDR_W(ADDR_W)) order_map_i (
        .start_i (start_w),
        .beat_i  (beat_w),
        .order_i (order_w),
        .addr_o  (addr_o)
    );

endmodule : bst_addr_gen

// File: rtl/bst_addr_gen_chk.sv
// Module bst_addr_gen_chk
// Temporal checks on the burst sequencer ports, attached by bind.
// Assumes: it sees only the top-level ports. Its own shadow start and beat
// registers track the interleaved relation.
module bst_addr_gen_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] start_i,
    input logic              adv_n_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] sh_start;
    logic [ADDR_W-1:0] sh_beat;

    // Shadow tracking of the start address and advances seen on the ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_start <= '0;
            sh_beat  <= '0;
        end else if (load_i) begin
            sh_start <= start_i;
            sh_beat  <= '0;
        end else if (!adv_n_i) begin
            sh_beat  <= sh_beat + ONE;
        end
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0));

    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(start_i)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) ##1 $stable(mode_i) |-> $stable(addr_o));

    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !mode_i) ##1 !mode_i
            |-> (addr_o == $past(addr_o) + ONE));

    a_r5_interleave: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> (addr_o == (sh_start ^ sh_beat)));

endmodule : bst_addr_gen_chk

bind bst_addr_gen bst_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_n_i (adv_n_i),
    .mode_i  (mode_i),
    .addr_o  (addr_o)
);

// File: tb/bst_addr_gen_tb_top.sv
`timescale 1ns/1ps
// Bench for bst_addr_gen. It drives a 2-bit copy and a 3-bit copy with the
// same stimulus, and compares both against models kept in the bench.
module bst_addr_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load;
    logic [2:0] start;
    logic       adv_n;
    logic       mode;
    logic [1:0] addr2;
    logic [2:0] addr3;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    // Bench models: start and beat counts for each width
    logic [1:0] m_start2, m_beat2;
    logic [2:0] m_start3, m_beat3;

    always #2.5 clk = ~clk;

    bst_addr_gen #(.ADDR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .start_i(start[1:0]),
        .adv_n_i(adv_n), .mode_i(mode), .addr_o(addr2)
    );

    bst_addr_gen #(.ADDR_W(3)) dut3_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .start_i(start),
        .adv_n_i(adv_n), .mode_i(mode), .addr_o(addr3)
    );

    function automatic logic [1:0] exp2(logic [1:0] s, logic [1:0] k, logic md);
        return md ? (s ^ k) : (s + k);
    endfunction

    function automatic logic [2:0] exp3(logic [2:0] s, logic [2:0] k, logic md);
        return md ? (s ^ k) : (s + k);
    endfunction

    task automatic check(string req, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Model update, mirroring the requirements at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start2 <= '0; m_beat2 <= '0; m_start3 <= '0; m_beat3 <= '0;
        end else if (load) begin
            m_start2 <= start[1:0]; m_beat2 <= '0;
            m_start3 <= start;      m_beat3 <= '0;
        end else if (!adv_n) begin
            m_beat2 <= m_beat2 + 2'd1;
            m_beat3 <= m_beat3 + 3'd1;
        end
    end

    // Drive one cycle of inputs, then sample at the following falling edge
    task automatic step(logic ld, logic [2:0] st, logic an, logic md);
        load = ld; start = st; adv_n = an; mode = md;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_both(string req);
        check(req, addr2, exp2(m_start2, m_beat2, mode));
        check(req, addr3, exp3(m_start3, m_beat3, mode));
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        rst_n = 1'b0; load = 1'b0; start = '0; adv_n = 1'b0; mode = 1'b1;
        @(negedge clk);
        step(1'b1, 3'd5, 1'b0, 1'b1);
        // R1: reset state, even with load and advance requested
        check("R1", addr2, 0);
        check("R1", addr3, 0);
        rst_n = 1'b1;

        // R2/R4/R5/R7: every start, both modes, full walk with exact order
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                step(1'b1, 3'(s), 1'b1, md[0]);
                check("R2", addr2, s);
                for (int k = 1; k <= 4; k++) begin
                    step(1'b0, 3'd0, 1'b0, md[0]);
                    if (k == 4) check("R7", addr2, s);
                    else if (md == 0) check("R4", addr2, (s + k) % 4);
                    else check("R5", addr2, s ^ k);
                end
            end
        end

        // R7: eight-step wrap on the 3-bit copy, both modes
        for (int md = 0; md < 2; md++) begin
            step(1'b1, 3'd6, 1'b1, md[0]);
            for (int k = 0; k < 8; k++) step(1'b0, 3'd0, 1'b0, md[0]);
            check("R7", addr3, 6);
        end

        // R3: load with advance low shows the start, not the next address
        step(1'b1, 3'd3, 1'b0, 1'b0);
        check("R3", addr2, 3);
        check("R3", addr3, 3);
        step(1'b0, 3'd0, 1'b0, 1'b0);
        check("R4", addr3, 4);   // R4: carry into bit 2 on 3-bit copy

        // R6: stall holds position
        held = addr2;
        step(1'b0, 3'd7, 1'b1, 1'b0);
        step(1'b0, 3'd1, 1'b1, 1'b0);
        check("R6", addr2, held);
        check("R6", addr3, 4);

        // R8: mode flip re-maps immediately without an edge
        step(1'b1, 3'd1, 1'b1, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0);
        check("R8", addr2, 3);   // linear 1+2
        mode = 1'b1; #1;
        check("R8", addr2, 1 ^ 2);
        check("R8", addr3, 1 ^ 2);
        @(negedge clk);

        // Random mix against the model
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            step((r[3:0] == 4'd0), 3'(r[6:4]), r[8], (r[13:10] == 4'd0) ? ~mode : mode);
            check_both("R4/R5/R6 random");
        end

        // R1: reset mid-burst
        step(1'b0, 3'd0, 1'b0, 1'b1);
        rst_n = 1'b0;
        step(1'b0, 3'd0, 1'b0, 1'b0);
        check("R1", addr2, 0);
        check("R1", addr3, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule : bst_addr_gen_tb_top